// File: doc/BRIEF.md
# Byte-Lane Late-Write SRAM Core

A small synchronous word memory built from independent byte lanes. Every cycle the block registers the address and the active-low controls on the rising clock edge. A write command only names the address and the lanes to update. Its data is sampled on the following edge and held in a staging register. The staged word is written into the array on the edge after that. Because of this, a read issued on the same edge the data is captured would see stale array contents. The block therefore merges the staged lanes into the read result whenever the addresses match.

Lane selection combines two controls. A global write strobe writes every lane. Otherwise a byte-write enable passes the per-lane strobes through. Any cycle that writes no lane is a read. The output enable only gates the read result, and a disabled output is modelled as zero data with a cleared valid flag.

Top module: `bw_sram_core`

## Requirements
- R1: With `en_ni` low and `all_wr_ni` low, the command writes all four lanes, whatever `byte_wr_ni` and `lane_wr_ni` hold.
- R2: With `all_wr_ni` high and `byte_wr_ni` high, the command is a read and the lane strobes have no effect on memory.
- R3: With `all_wr_ni` high and `byte_wr_ni` low, lane g (bits 8g+7..8g) is written exactly when `lane_wr_ni[g]` is low; if every strobe is high the command is a read.
- R4: A read command registered on edge k drives `rdata_o` and `rdata_vld_o` from just after edge k. Write data for a command registered on edge k is sampled from `wdata_i` on edge k+1.
- R5: A read to the address of the write registered one edge earlier returns the new data on the written lanes and the stored data on all other lanes.
- R6: A read to any other address returns array contents and is not affected by the staged write.
- R7: While `oe_ni` is high, `rdata_vld_o` is 0 and `rdata_o` is 0, regardless of earlier cycles.
- R8: A cycle with `en_ni` high starts no operation (`rdata_vld_o` 0), yet a write whose data arrives in that cycle still completes.
- R9: Staged data is committed to the array on the edge after it is captured, and later reads return it.
- R10: After reset `rdata_vld_o` and `rdata_o` are 0 and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Chip enable, active low |
| addr_i | input | ADDR_W | Word address |
| all_wr_ni | input | 1 | Global write of all lanes, active low |
| byte_wr_ni | input | 1 | Enables per-lane strobes, active low |
| lane_wr_ni | input | LANES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data, one cycle after its command |
| rdata_o | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_vld_o | output | 1 | Read data driven (low models high impedance) |

## Verification
The assertions watch every cycle for correct command decoding. They check that global write registers an all-lane write, and that a disabled byte-write enable registers a read. They also check that an idle cycle registers nothing, that a write command always leads to data capture on the next edge, and that each enabled lane reaches the array one edge later. The bench is needed for the forwarding itself. It sweeps every lane mask over every address, and it checks partial-lane merging, reads to non-matching addresses, output-enable gating and completion across an idle cycle. In each case it compares the output against an arithmetic memory model.

// File: rtl/bw_sram_pkg.sv
package bw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bw_wr_decode.sv
module bw_wr_decode
  import bw_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_ni,
  input  logic             all_wr_ni,
  input  logic             byte_wr_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  output op_e              op_o,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    op_o   = OP_IDLE;
    mask_o = '0;
    if (!en_ni) begin
      if (!all_wr_ni) begin
        op_o   = OP_WRITE;
        mask_o = '1;
      end else if (!byte_wr_ni && (~lane_wr_ni != '0)) begin
        op_o   = OP_WRITE;
        mask_o = ~lane_wr_ni;
      end else begin
        op_o = OP_READ;
      end
    end
  end
endmodule

// File: rtl/bw_sram_array.sv
module bw_sram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wmask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w][g*LANE_W +: LANE_W] <= '0;
      end else if (we_i && wmask_i[g]) begin
        mem_q[waddr_i][g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end

    assert_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wmask_i[g]) |=>
        mem_q[$past(waddr_i)][g*LANE_W +: LANE_W] == $past(wdata_i[g*LANE_W +: LANE_W]));
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bw_fwd_merge.sv
module bw_fwd_merge #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [LANES*LANE_W-1:0] arr_data_i,
  input  logic                    hold_vld_i,
  input  logic [ADDR_W-1:0]       hold_addr_i,
  input  logic [LANES-1:0]        hold_mask_i,
  input  logic [LANES*LANE_W-1:0] hold_data_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  logic hit;
  assign hit = hold_vld_i && (hold_addr_i == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[g*LANE_W +: LANE_W] = (hit && hold_mask_i[g]) ?
        hold_data_i[g*LANE_W +: LANE_W] : arr_data_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bw_sram_core.sv
module bw_sram_core
  import bw_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    all_wr_ni,
  input  logic                    byte_wr_ni,
  input  logic [LANES-1:0]        lane_wr_ni,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_vld_o
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic [LANES-1:0]  op_mask;

  logic              rd_vld_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              cmd_wr_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [LANES-1:0]  cmd_mask_q;
  logic              hold_vld_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [LANES-1:0]  hold_mask_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] merged;

  bw_wr_decode #(.LANES(LANES)) u_dec (
    .en_ni      (en_ni),
    .all_wr_ni  (all_wr_ni),
    .byte_wr_ni (byte_wr_ni),
    .lane_wr_ni (lane_wr_ni),
    .op_o       (op),
    .mask_o     (op_mask)
  );

  // command stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q   <= 1'b0;
      rd_addr_q  <= '0;
      cmd_wr_q   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_mask_q <= '0;
    end else begin
      rd_vld_q <= (op == OP_READ);
      cmd_wr_q <= (op == OP_WRITE);
      if (op == OP_READ)  rd_addr_q <= addr_i;
      if (op == OP_WRITE) begin
        cmd_addr_q <= addr_i;
        cmd_mask_q <= op_mask;
      end
    end
  end

  // late data capture; commits on the next edge regardless of new commands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_addr_q <= '0;
      hold_mask_q <= '0;
      hold_data_q <= '0;
    end else begin
      hold_vld_q <= cmd_wr_q;
      if (cmd_wr_q) begin
        hold_addr_q <= cmd_addr_q;
        hold_mask_q <= cmd_mask_q;
        hold_data_q <= wdata_i;
      end
    end
  end

  bw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hold_vld_q),
    .waddr_i (hold_addr_q),
    .wmask_i (hold_mask_q),
    .wdata_i (hold_data_q),
    .raddr_i (rd_addr_q),
    .rdata_o (arr_rdata)
  );

  bw_fwd_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fwd (
    .rd_addr_i   (rd_addr_q),
    .arr_data_i  (arr_rdata),
    .hold_vld_i  (hold_vld_q),
    .hold_addr_i (hold_addr_q),
    .hold_mask_i (hold_mask_q),
    .hold_data_i (hold_data_q),
    .data_o      (merged)
  );

  assign rdata_vld_o = rd_vld_q && !oe_ni;
  assign rdata_o     = rdata_vld_o ? merged : '0;

  assert_all_lanes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!en_ni && !all_wr_ni)) |->
      (cmd_wr_q && cmd_mask_q == '1 && !rd_vld_q));

  assert_read_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!en_ni && all_wr_ni && byte_wr_ni)) |->
      (rd_vld_q && !cmd_wr_q));

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_q |=> (hold_vld_q && hold_addr_q == $past(cmd_addr_q)
                  && hold_mask_q == $past(cmd_mask_q)));

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(en_ni)) |-> (!rd_vld_q && !cmd_wr_q));
endmodule

// File: tb/sim_bw_sram_core.sv
module sim_bw_sram_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_ni = 1'b1;
  logic [3:0]  addr_i = '0;
  logic        all_wr_ni = 1'b1;
  logic        byte_wr_ni = 1'b1;
  logic [3:0]  lane_wr_ni = 4'hF;
  logic        oe_ni = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rdata_vld_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdl [16];
  logic        p_wr = 1'b0;
  logic [3:0]  p_addr = '0;
  logic [3:0]  p_mask = '0;

  always #10 clk_i = ~clk_i;

  bw_sram_core u0 (.*);

  function automatic logic [31:0] pat(input int a, input int k);
    return (32'h9E3779B9 * (a + 1)) ^ (32'h01010101 * k) ^ 32'h5A00_00A5;
  endfunction

  task automatic check(input string tag, input logic vld, input logic [31:0] d,
                       input logic evld, input logic [31:0] ed);
    checks++;
    if (vld !== evld || d !== ed) begin
      errors++;
      $display("FAIL %s: vld=%0b data=%08h expected vld=%0b data=%08h", tag, vld, d, evld, ed);
    end
  endtask

  // one cycle: drive at negedge, edge, then check at next negedge
  task automatic step(input logic en_n, input logic gw_n, input logic bwe_n,
                      input logic [3:0] lw_n, input logic oe_n, input logic [3:0] a,
                      input logic [31:0] wd, input string tag);
    logic rd, wr;
    logic [3:0] m;
    en_ni = en_n; all_wr_ni = gw_n; byte_wr_ni = bwe_n; lane_wr_ni = lw_n;
    oe_ni = oe_n; addr_i = a; wdata_i = wd;
    @(posedge clk_i);
    if (p_wr)
      for (int g = 0; g < 4; g++)
        if (p_mask[g]) mdl[p_addr][g*8 +: 8] = wd[g*8 +: 8];
    m = !gw_n ? 4'hF : (!bwe_n ? ~lw_n : 4'h0);
    wr = !en_n && (m != 0);
    rd = !en_n && !wr;
    p_wr = wr; p_addr = a; p_mask = m;
    @(negedge clk_i);
    if (rd && !oe_n) check(tag, rdata_vld_o, rdata_o, 1'b1, mdl[a]);
    else             check(tag, rdata_vld_o, rdata_o, 1'b0, 32'h0);
  endtask

  task automatic rd_step(input logic [3:0] a, input logic [31:0] wd, input string tag);
    step(1'b0, 1'b1, 1'b1, 4'h0, 1'b0, a, wd, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R10 reset", rdata_vld_o, rdata_o, 1'b0, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 idle", rdata_vld_o, rdata_o, 1'b0, 32'h0);
    for (int a = 0; a < 16; a++) rd_step(4'(a), 32'hDEAD_BEEF, "R10 zero memory");

    // R1: global write ignores byte controls
    for (int a = 0; a < 16; a++)
      step(1'b0, 1'b0, 1'(a & 1), 4'(a), 1'b0, 4'(a), pat(a - 1, 1), "R1 global write");
    for (int a = 0; a < 16; a++) rd_step(4'(a), pat(15, 1), "R1 readback");

    // R5/R6/R9: forward on match, array on mismatch, commit afterwards
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 4'(a), 32'h0, "R4 write cmd");
      rd_step(4'((a + 5) % 16), pat(a, 2), "R6 other address");
      step(1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 4'(a), 32'h0, "R4 write cmd");
      rd_step(4'(a), pat(a, 3), "R5 pass-through");
      rd_step(4'(a), 32'h0, "R9 committed");
    end

    // R3: every lane mask on every address, then forwarded read
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 16; a++) begin
        step(1'b0, 1'b1, 1'b0, ~4'(m), 1'b0, 4'(a), 32'h0, "R3 byte write");
        rd_step(4'(a), pat(a, m + 4), "R5 partial pass-through");
        rd_step(4'((a + 1) % 16), 32'h0, "R9 neighbour");
        rd_step(4'(a), 32'h0, "R3 committed lanes");
      end

    // R2: byte-write disabled ignores strobes
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 4'(a), 32'h0, "R2 strobes ignored");
      rd_step(4'(a), 32'hFFFF_FFFF, "R2 memory unchanged");
    end

    // R8: idle cycle still completes the staged write
    for (int a = 0; a < 4; a++) begin
      step(1'b0, 1'b1, 1'b0, 4'b1010, 1'b0, 4'(a), 32'h0, "R8 write cmd");
      step(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 4'(a), pat(a, 40), "R8 idle");
      step(1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 4'(a), 32'h0, "R8 idle");
      rd_step(4'(a), 32'h0, "R8 completed");
    end

    // R7: output enable high blocks output
    for (int a = 0; a < 4; a++) begin
      step(1'b0, 1'b0, 1'b1, 4'hF, 1'b1, 4'(a), 32'h0, "R7 write oe high");
      step(1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 4'(a), pat(a, 50), "R7 high-z");
      oe_ni = 1'b0;
      #1;
      check("R7 oe released", rdata_vld_o, rdata_o, 1'b1, mdl[a]);
      rd_step(4'(a), 32'h0, "R7 read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule